// File: doc/BRIEF.md
# Shadow Register Bank Selector

This block owns a 32-bit machine-mode status register that names the register bank a core is currently running on, either the general-purpose bank (index 0) or one of the shadow banks (any non-zero index), together with the bank that was running before it. When automatic switching is enabled, interrupt entry and exit strobes move these two indices without software help. Banks nest with interrupt pre-emption, and an internal stack keeps older indices so they return in order as handlers finish.

A build-time mode picks the policy. In single mode, every interrupt runs on bank 1. In nested mode, each interrupt runs on the bank whose index equals its level. The nested-minus-one mode also uses level-numbered banks, but the outermost interrupt keeps running on the general bank. Only pre-empting interrupts move to shadow banks. Software reads the register at any time and may rewrite the enable bit and both indices. The banked storage and the interrupt arbiter sit outside this block.

Top module: `shadow_bank_ctrl`

## Requirements
- R1: After reset the register reads 0: automatic switching is off, both indices are 0, and the overflow flag is low.
- R2: The register reads as enable in bit 31, zero in bits 30:16, the previous index in bits 15:8 and the active index in bits 7:0. Bits 30:16 of a write are discarded. The active_bank and prev_bank ports equal the two fields.
- R3: While the enable bit is 0, entry and exit strobes change neither index.
- R4: In single mode, an enabled entry sets previous to 0 and active to 1. The matching exit returns active to 0.
- R5: In nested mode, an enabled entry copies the old active index into previous and loads active with irq_level. The first entry therefore gives previous 0.
- R6: In nested mode, an enabled exit moves previous into active and reloads previous from the most recently saved index. The outermost exit leaves active at 0.
- R7: In nested-minus-one mode, the outermost entry leaves both indices at 0. The first pre-emption gives previous 0 and active equal to its level. Exiting that pre-emption returns both indices to 0.
- R8: An enabled entry while STACK_DEPTH interrupts are already active leaves both indices unchanged. It raises overflow_err, which stays high until reset.
- R9: An exit strobe while no interrupt is active is ignored.
- R10: When entry and exit strobe in the same cycle, only the entry takes effect.
- R11: A software write while interrupts are active replaces both indices but leaves the nesting depth unchanged. A later exit therefore still consumes one saved index.
- R12: When an enabled strobe and a software write fall in the same cycle, the indices follow the strobe and the enable bit takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_enter | input | 1 | Single-cycle interrupt entry strobe |
| irq_exit | input | 1 | Single-cycle interrupt return strobe |
| irq_level | input | 8 | Level of the interrupt being entered |
| csr_wr_en | input | 1 | Software write strobe for the register |
| csr_wr_data | input | 32 | Software write value |
| csr_rd_data | output | 32 | Current register value |
| active_bank | output | 8 | Index of the bank in use |
| prev_bank | output | 8 | Index of the bank used before |
| overflow_err | output | 1 | Sticky flag: entry refused because the stack was full |

## Verification
Every result is registered, so each strobe or write is visible on the outputs exactly one clock edge after the cycle it is presented in. Nothing takes longer than one cycle. The driver holds each stimulus for one cycle ending at a rising edge and queues the expected register and flag values right after that edge. The monitor compares them at the following falling edge, which is the first stable point after the update. An ignored strobe is judged at that same point, by checking that the register still holds the value it had before.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
  localparam int CSR_W  = 32;
  localparam int BANK_W = 8;

  typedef enum logic [1:0] {
    SBK_SINGLE    = 2'd0,
    SBK_NESTED    = 2'd1,
    SBK_NESTED_M1 = 2'd2
  } sbk_mode_e;

  typedef struct packed {
    logic              en;
    logic [14:0]       rsvd;
    logic [BANK_W-1:0] prev;
    logic [BANK_W-1:0] act;
  } sbk_csr_t;
endpackage

// File: rtl/sbk_stack.sv
module sbk_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] top_ptr;
  logic [CW-1:0] cnt;

  assign top_ptr = wr_ptr - 1'b1;
  assign top     = mem[top_ptr];
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wr_ptr <= '0;
    end else if (push) begin
      cnt    <= cnt + 1'b1;
      wr_ptr <= wr_ptr + 1'b1;
    end else if (pop) begin
      cnt    <= cnt - 1'b1;
      wr_ptr <= wr_ptr - 1'b1;
    end
  end

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  p_single_op_r10: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/sbk_event.sv
module sbk_event
  import sbk_pkg::*;
#(
  parameter sbk_mode_e MODE = SBK_NESTED
) (
  input  logic              en,
  input  logic              irq_enter,
  input  logic              irq_exit,
  input  logic [BANK_W-1:0] level,
  input  logic              stk_empty,
  input  logic              stk_full,
  output logic              do_push,
  output logic              do_pop,
  output logic              ovf_set,
  output logic [BANK_W-1:0] new_act
);
  logic unused_lvl;
  assign unused_lvl = ^level;

  assign do_push = en & irq_enter & ~stk_full;
  assign ovf_set = en & irq_enter &  stk_full;
  assign do_pop  = en & irq_exit  & ~irq_enter & ~stk_empty;

  generate
    if (MODE == SBK_SINGLE) begin : g_single
      assign new_act = BANK_W'(1);
    end else if (MODE == SBK_NESTED_M1) begin : g_m1
      assign new_act = stk_empty ? '0 : level;
    end else begin : g_nested
      assign new_act = level;
    end
  endgenerate
endmodule

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
  import sbk_pkg::*;
#(
  parameter sbk_mode_e MODE        = SBK_NESTED,
  parameter int        STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_enter,
  input  logic              irq_exit,
  input  logic [BANK_W-1:0] irq_level,
  input  logic              csr_wr_en,
  input  logic [CSR_W-1:0]  csr_wr_data,
  output logic [CSR_W-1:0]  csr_rd_data,
  output logic [BANK_W-1:0] active_bank,
  output logic [BANK_W-1:0] prev_bank,
  output logic              overflow_err
);
  sbk_csr_t          wr_view;
  sbk_csr_t          rd_view;
  logic              en_q;
  logic              ovf_q;
  logic [BANK_W-1:0] act_q;
  logic [BANK_W-1:0] prev_q;
  logic              do_push;
  logic              do_pop;
  logic              ovf_set;
  logic [BANK_W-1:0] new_act;
  logic [BANK_W-1:0] stk_top;
  logic              stk_empty;
  logic              stk_full;
  logic              unused_rsvd;

  assign wr_view     = sbk_csr_t'(csr_wr_data);
  assign unused_rsvd = ^wr_view.rsvd;

  sbk_event #(.MODE(MODE)) u_event (
    .en        (en_q),
    .irq_enter (irq_enter),
    .irq_exit  (irq_exit),
    .level     (irq_level),
    .stk_empty (stk_empty),
    .stk_full  (stk_full),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .ovf_set   (ovf_set),
    .new_act   (new_act)
  );

  sbk_stack #(.DEPTH(STACK_DEPTH), .W(BANK_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .pop       (do_pop),
    .push_data (prev_q),
    .top       (stk_top),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ovf_q  <= 1'b0;
      act_q  <= '0;
      prev_q <= '0;
    end else begin
      if (csr_wr_en) en_q <= wr_view.en;
      if (ovf_set) ovf_q <= 1'b1;
      if (do_push) begin
        prev_q <= act_q;
        act_q  <= new_act;
      end else if (do_pop) begin
        act_q  <= prev_q;
        prev_q <= stk_top;
      end else if (csr_wr_en) begin
        prev_q <= wr_view.prev;
        act_q  <= wr_view.act;
      end
    end
  end

  always_comb begin
    rd_view      = '0;
    rd_view.en   = en_q;
    rd_view.prev = prev_q;
    rd_view.act  = act_q;
  end

  assign csr_rd_data  = rd_view;
  assign active_bank  = act_q;
  assign prev_bank    = prev_q;
  assign overflow_err = ovf_q;

  p_off_no_move_r3: assert property (@(posedge clk) disable iff (rst)
    (!csr_rd_data[31] && !csr_wr_en && (irq_enter || irq_exit))
      |=> $stable({prev_bank, active_bank}));
  p_exit_restore_r6: assert property (@(posedge clk) disable iff (rst)
    (csr_rd_data[31] && irq_exit && !irq_enter && !stk_empty)
      |=> active_bank == $past(prev_bank));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow_err |=> overflow_err);
  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (csr_rd_data[31] && irq_enter && stk_full && !csr_wr_en)
      |=> $stable({prev_bank, active_bank}));
  p_entry_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (csr_rd_data[31] && irq_enter && irq_exit && !stk_full)
      |=> prev_bank == $past(active_bank));
  p_exit_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (stk_empty && irq_exit && !irq_enter && !csr_wr_en)
      |=> $stable({prev_bank, active_bank}));
endmodule

// File: tb/shadow_bank_ctrl_bench.sv
module shadow_bank_ctrl_bench;
  import sbk_pkg::*;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          id;
    logic [31:0] exp_csr;
    logic        exp_ovf;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ent [3];
  logic        ext [3];
  logic        wr  [3];
  logic [7:0]  level = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd  [3];
  logic [7:0]  act [3];
  logic [7:0]  prv [3];
  logic        ov  [3];
  item_t       sb_q [$];
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_bank_ctrl #(.MODE(SBK_NESTED), .STACK_DEPTH(4)) u_shadow_bank_ctrl (
    .clk(clk), .rst(rst), .irq_enter(ent[0]), .irq_exit(ext[0]), .irq_level(level),
    .csr_wr_en(wr[0]), .csr_wr_data(wdata), .csr_rd_data(rd[0]),
    .active_bank(act[0]), .prev_bank(prv[0]), .overflow_err(ov[0]));

  shadow_bank_ctrl #(.MODE(SBK_SINGLE), .STACK_DEPTH(4)) u_shadow_bank_ctrl_single (
    .clk(clk), .rst(rst), .irq_enter(ent[1]), .irq_exit(ext[1]), .irq_level(level),
    .csr_wr_en(wr[1]), .csr_wr_data(wdata), .csr_rd_data(rd[1]),
    .active_bank(act[1]), .prev_bank(prv[1]), .overflow_err(ov[1]));

  shadow_bank_ctrl #(.MODE(SBK_NESTED_M1), .STACK_DEPTH(4)) u_shadow_bank_ctrl_m1 (
    .clk(clk), .rst(rst), .irq_enter(ent[2]), .irq_exit(ext[2]), .irq_level(level),
    .csr_wr_en(wr[2]), .csr_wr_data(wdata), .csr_rd_data(rd[2]),
    .active_bank(act[2]), .prev_bank(prv[2]), .overflow_err(ov[2]));

  task automatic apply(input int id, input logic e, input logic x, input logic w,
                       input logic [7:0] lvl, input logic [31:0] wd,
                       input logic [31:0] exp_csr, input logic exp_ovf, input string tag);
    @(negedge clk);
    ent[id] = e; ext[id] = x; wr[id] = w; level = lvl; wdata = wd;
    @(posedge clk);
    #1;
    ent[id] = 1'b0; ext[id] = 1'b0; wr[id] = 1'b0;
    sb_q.push_back('{id, exp_csr, exp_ovf, tag});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rd[it.id] !== it.exp_csr || ov[it.id] !== it.exp_ovf) begin
          failures++;
          $display("FAIL %s dut%0d csr=%h ovf=%b expected csr=%h ovf=%b",
                   it.tag, it.id, rd[it.id], ov[it.id], it.exp_csr, it.exp_ovf);
        end
        checks++;
        if (act[it.id] !== it.exp_csr[7:0] || prv[it.id] !== it.exp_csr[15:8]) begin
          failures++;
          $display("FAIL R2 ports dut%0d act=%h prev=%h expected act=%h prev=%h",
                   it.id, act[it.id], prv[it.id], it.exp_csr[7:0], it.exp_csr[15:8]);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 3; i++) begin
      ent[i] = 1'b0; ext[i] = 1'b0; wr[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state on every mode
    apply(0, 0, 0, 0, 8'd0, 32'h0, 32'h0000_0000, 1'b0, "R1");
    apply(1, 0, 0, 0, 8'd0, 32'h0, 32'h0000_0000, 1'b0, "R1");
    apply(2, 0, 0, 0, 8'd0, 32'h0, 32'h0000_0000, 1'b0, "R1");
    // R2 reserved bits dropped; R3 strobes ignored while disabled
    apply(0, 0, 0, 1, 8'd0, 32'h7FFF_1234, 32'h0000_1234, 1'b0, "R2");
    apply(0, 1, 0, 0, 8'd9, 32'h0, 32'h0000_1234, 1'b0, "R3");
    apply(0, 0, 1, 0, 8'd0, 32'h0, 32'h0000_1234, 1'b0, "R3");
    apply(0, 0, 0, 1, 8'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, "R2");
    // R9 exit with nothing active
    apply(0, 0, 1, 0, 8'd0, 32'h0, 32'h8000_0000, 1'b0, "R9");
    // R5 nested entries
    apply(0, 1, 0, 0, 8'd63,  32'h0, 32'h8000_003F, 1'b0, "R5");
    apply(0, 1, 0, 0, 8'd127, 32'h0, 32'h8000_3F7F, 1'b0, "R5");
    apply(0, 1, 0, 0, 8'd191, 32'h0, 32'h8000_7FBF, 1'b0, "R5");
    apply(0, 1, 0, 0, 8'd255, 32'h0, 32'h8000_BFFF, 1'b0, "R5");
    // R8 overflow with four active
    apply(0, 1, 0, 0, 8'd10, 32'h0, 32'h8000_BFFF, 1'b1, "R8");
    // R6 unwinding
    apply(0, 0, 1, 0, 8'd0, 32'h0, 32'h8000_7FBF, 1'b1, "R6");
    apply(0, 0, 1, 0, 8'd0, 32'h0, 32'h8000_3F7F, 1'b1, "R6");
    apply(0, 0, 1, 0, 8'd0, 32'h0, 32'h8000_003F, 1'b1, "R6");
    apply(0, 0, 1, 0, 8'd0, 32'h0, 32'h8000_0000, 1'b1, "R6");
    // R10 entry wins over exit
    apply(0, 1, 1, 0, 8'd5, 32'h0, 32'h8000_0005, 1'b1, "R10");
    // R11 write during active interrupt keeps depth
    apply(0, 0, 0, 1, 8'd0, 32'h8000_0720, 32'h8000_0720, 1'b1, "R11");
    apply(0, 0, 1, 0, 8'd0, 32'h0, 32'h8000_0007, 1'b1, "R11");
    apply(0, 0, 1, 0, 8'd0, 32'h0, 32'h8000_0007, 1'b1, "R11");
    // R12 strobe plus write in one cycle
    apply(0, 1, 0, 1, 8'd9, 32'h0000_1111, 32'h0000_0709, 1'b1, "R12");
    apply(0, 1, 0, 0, 8'd3, 32'h0, 32'h0000_0709, 1'b1, "R12");
    // R4 single mode
    apply(1, 0, 0, 1, 8'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, "R4");
    apply(1, 1, 0, 0, 8'd40, 32'h0, 32'h8000_0001, 1'b0, "R4");
    apply(1, 0, 1, 0, 8'd0, 32'h0, 32'h8000_0000, 1'b0, "R4");
    // R7 nested-minus-one mode
    apply(2, 0, 0, 1, 8'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, "R7");
    apply(2, 1, 0, 0, 8'd127, 32'h0, 32'h8000_0000, 1'b0, "R7");
    apply(2, 1, 0, 0, 8'd191, 32'h0, 32'h8000_00BF, 1'b0, "R7");
    apply(2, 1, 0, 0, 8'd200, 32'h0, 32'h8000_BFC8, 1'b0, "R7");
    apply(2, 0, 1, 0, 8'd0, 32'h0, 32'h8000_00BF, 1'b0, "R7");
    apply(2, 0, 1, 0, 8'd0, 32'h0, 32'h8000_0000, 1'b0, "R7");
    apply(2, 0, 1, 0, 8'd0, 32'h0, 32'h8000_0000, 1'b0, "R7");
    apply(2, 0, 1, 0, 8'd0, 32'h0, 32'h8000_0000, 1'b0, "R9");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule